// File: doc/BRIEF.md
# Set/Clear Peripheral Register Interface

This block is the register front end of a peripheral on a 32-bit slave bus. It holds a command register whose written ones become single-cycle pulses, a read/write configuration (mode) register, a general data register and a live status view. A flag field and an interrupt mask can each be changed only through a pair of addresses: one sets the bits written as one and the other clears them. A single store therefore changes any chosen subset of bits without a read-modify-write sequence, and nothing else running at the same time can overwrite those bits.

The peripheral logic behind the block drives the status inputs and uses the mode, flag, data and command outputs. A registered interrupt line is high while any status bit is high and its mask bit is also set. Every access is handled as a whole word: the two lowest address bits are ignored.

Top module: `setClrRegs`

## Requirements
- R1: The two lowest bits of `busAddr` are ignored, so any byte or half-word address is decoded as the word that contains it.
- R2: A write to offset 0x00 drives `cmdPulse` with the low CMD_W write-data bits for exactly one cycle, starting the cycle after the write. Zero bits produce no pulse, and offset 0x00 reads as zero.
- R3: The mode register at offset 0x04 is readable and writable, holds MODE_W bits, resets to 0 and drives `modeOut`.
- R4: A write to offset 0x08 sets every flag bit that is written as one. A write to offset 0x0C clears every flag bit that is written as one. Bits written as zero keep their value. The flags reset to 0, read back at offset 0x10 and drive `flagsOut`.
- R5: The interrupt mask resets to 0. Offset 0x14 sets mask bits written as one, offset 0x18 clears mask bits written as one, and the mask reads back at offset 0x1C.
- R6: Offset 0x20 reads the current `statusIn` value.
- R7: `irq` is a register loaded on each clock with the OR over all bits of (`statusIn` AND mask). It is low out of reset.
- R8: The data register at offset 0x24 is readable and writable, holds DATA_W bits, resets to 0 and drives `dataOut`.
- R9: Register bits above each field's width read as zero, and writes to them are ignored. Offsets 0x08, 0x0C, 0x14 and 0x18, and every offset from 0x28 upward, read as zero. A write to an unmapped offset changes no state.
- R10: `busRdata` is combinational and valid in the same cycle while `busSel` is high and `busWrite` is low. It is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request for this block |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| statusIn | input | STAT_W | Status bits from the peripheral |
| cmdPulse | output | CMD_W | One-cycle command strobes |
| modeOut | output | MODE_W | Mode configuration |
| flagsOut | output | FLAG_W | Set/clear flag field |
| dataOut | output | DATA_W | Data register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench writes to addresses whose low bits are not zero. A decoder that uses those bits would send the access to the wrong register, and the next readback would differ. Set and clear writes with mixed one and zero patterns are run against a shadow model. A design that did a plain load, or that inverted the wrong operand, would disturb bits that were written as zero. The bench checks that `cmdPulse` is zero one cycle after each command, which catches a pulse that stays high. It also compares `irq` with status AND mask once both have settled, which catches a missing mask term or an OR of the wrong vectors. Writes to unmapped offsets are followed by readbacks of every register, and a stray decode would show up there.

// File: rtl/spriPkg.sv
package spriPkg;
  typedef enum logic [3:0] {
    RID_CTRL  = 4'd0,
    RID_MODE  = 4'd1,
    RID_SET   = 4'd2,
    RID_CLR   = 4'd3,
    RID_FLAGS = 4'd4,
    RID_IEN   = 4'd5,
    RID_IDIS  = 4'd6,
    RID_IMASK = 4'd7,
    RID_STAT  = 4'd8,
    RID_DATA  = 4'd9,
    RID_NONE  = 4'd15
  } regId_e;

  typedef struct packed {
    logic   wrCmd;
    logic   wrMode;
    logic   wrSet;
    logic   wrClr;
    logic   wrIrqSet;
    logic   wrIrqClr;
    logic   wrData;
    regId_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/spriCtrl.sv
module spriCtrl
  import spriPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  regId_e           target;
  logic             unusedAddrLow;
  logic             wrEn;

  // word decode: lowest two address bits never take part (R1)
  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedAddrLow = ^busAddr[1:0];
  assign wrEn          = busSel && busWrite;

  always_comb begin
    case (wordIdx)
      IDX_W'(0): target = RID_CTRL;
      IDX_W'(1): target = RID_MODE;
      IDX_W'(2): target = RID_SET;
      IDX_W'(3): target = RID_CLR;
      IDX_W'(4): target = RID_FLAGS;
      IDX_W'(5): target = RID_IEN;
      IDX_W'(6): target = RID_IDIS;
      IDX_W'(7): target = RID_IMASK;
      IDX_W'(8): target = RID_STAT;
      IDX_W'(9): target = RID_DATA;
      default:   target = RID_NONE;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = (busSel && !busWrite) ? target : RID_NONE;
    strobe.wrCmd    = wrEn && (target == RID_CTRL);
    strobe.wrMode   = wrEn && (target == RID_MODE);
    strobe.wrSet    = wrEn && (target == RID_SET);
    strobe.wrClr    = wrEn && (target == RID_CLR);
    strobe.wrIrqSet = wrEn && (target == RID_IEN);
    strobe.wrIrqClr = wrEn && (target == RID_IDIS);
    strobe.wrData   = wrEn && (target == RID_DATA);
  end
endmodule

// File: rtl/spriDatapath.sv
module spriDatapath
  import spriPkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int MODE_W = 8,
  parameter int FLAG_W = 8,
  parameter int STAT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [31:0]       busWdata,
  input  logic [STAT_W-1:0] statusIn,
  output logic [31:0]       busRdata,
  output logic [CMD_W-1:0]  cmdPulse,
  output logic [MODE_W-1:0] modeOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [STAT_W-1:0] maskVec,
  output logic [DATA_W-1:0] dataOut,
  output logic              irq
);
  logic [CMD_W-1:0]  cmdQ;
  logic [MODE_W-1:0] modeQ;
  logic [FLAG_W-1:0] flagQ;
  logic [STAT_W-1:0] maskQ;
  logic [DATA_W-1:0] dataQ;
  logic              irqQ;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata;

  // command strobes live for one cycle only (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmdQ <= '0;
    else if (strobe.wrCmd)  cmdQ <= busWdata[CMD_W-1:0];
    else                    cmdQ <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeQ <= '0;
    else if (strobe.wrMode) modeQ <= busWdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (strobe.wrData) dataQ <= busWdata[DATA_W-1:0];
  end

  // set/clear fields: ones act, zeros leave bits alone (R4, R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagQ <= '0;
    else if (strobe.wrSet) flagQ <= flagQ | busWdata[FLAG_W-1:0];
    else if (strobe.wrClr) flagQ <= flagQ & ~busWdata[FLAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                maskQ <= '0;
    else if (strobe.wrIrqSet) maskQ <= maskQ | busWdata[STAT_W-1:0];
    else if (strobe.wrIrqClr) maskQ <= maskQ & ~busWdata[STAT_W-1:0];
  end

  // AND each status bit with its mask, OR the result, register it (R7)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusIn & maskQ);
  end

  always_comb begin
    case (strobe.rdSel)
      RID_MODE:  busRdata = 32'(modeQ);
      RID_FLAGS: busRdata = 32'(flagQ);
      RID_IMASK: busRdata = 32'(maskQ);
      RID_STAT:  busRdata = 32'(statusIn);
      RID_DATA:  busRdata = 32'(dataQ);
      default:   busRdata = '0;
    endcase
  end

  assign cmdPulse = cmdQ;
  assign modeOut  = modeQ;
  assign flagsOut = flagQ;
  assign maskVec  = maskQ;
  assign dataOut  = dataQ;
  assign irq      = irqQ;
endmodule

// File: rtl/setClrRegs.sv
module setClrRegs
  import spriPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int MODE_W = 8,
  parameter int FLAG_W = 8,
  parameter int STAT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [STAT_W-1:0] statusIn,
  output logic [CMD_W-1:0]  cmdPulse,
  output logic [MODE_W-1:0] modeOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              irq
);
  regStrobe_t        strobe;
  logic [STAT_W-1:0] maskVec;

  spriCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  spriDatapath #(
    .CMD_W(CMD_W), .MODE_W(MODE_W), .FLAG_W(FLAG_W),
    .STAT_W(STAT_W), .DATA_W(DATA_W)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .statusIn(statusIn),
    .busRdata(busRdata),
    .cmdPulse(cmdPulse),
    .modeOut (modeOut),
    .flagsOut(flagsOut),
    .maskVec (maskVec),
    .dataOut (dataOut),
    .irq     (irq)
  );
endmodule

// File: rtl/spriChecker.sv
module spriChecker #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 4,
  parameter int FLAG_W = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [STAT_W-1:0] statusIn,
  input logic [CMD_W-1:0]  cmdPulse,
  input logic [FLAG_W-1:0] flagsOut,
  input logic [STAT_W-1:0] maskVec,
  input logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  logic             wr;
  assign idx = busAddr[ADDR_W-1:2];
  assign wr  = busSel && busWrite;

  a_r2_pulse_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != '0) |-> ($past(wr && idx == IDX_W'(0)) &&
                          cmdPulse == $past(busWdata[CMD_W-1:0])));

  a_r4_set_ones: assert property (@(posedge clk) disable iff (!rstN)
    (wr && idx == IDX_W'(2)) |=>
      ((flagsOut & $past(busWdata[FLAG_W-1:0])) == $past(busWdata[FLAG_W-1:0])));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rstN)
    (wr && idx == IDX_W'(3)) |=> ((flagsOut & $past(busWdata[FLAG_W-1:0])) == '0));

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wr && (idx == IDX_W'(2) || idx == IDX_W'(3))) |=> $stable(flagsOut));

  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wr && (idx == IDX_W'(5) || idx == IDX_W'(6))) |=> $stable(maskVec));

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(statusIn & maskVec)));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && idx >= IDX_W'(10)) |-> (busRdata == '0));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |-> (busRdata == '0));
endmodule

bind setClrRegs spriChecker #(
  .ADDR_W(ADDR_W), .CMD_W(CMD_W), .FLAG_W(FLAG_W), .STAT_W(STAT_W)
) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .statusIn(statusIn), .cmdPulse(cmdPulse), .flagsOut(flagsOut),
  .maskVec(maskVec), .irq(irq)
);

// File: tb/setClrRegs_test.sv
`timescale 1ns/1ps
module setClrRegs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  statusIn = '0;
  logic [3:0]  cmdPulse;
  logic [7:0]  modeOut;
  logic [7:0]  flagsOut;
  logic [15:0] dataOut;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  mMode = '0;
  logic [7:0]  mFlags = '0;
  logic [7:0]  mMask = '0;
  logic [15:0] mData = '0;
  logic [3:0]  lastPulse;

  always #2.5 clk = ~clk;

  setClrRegs uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .statusIn(statusIn), .cmdPulse(cmdPulse), .modeOut(modeOut),
    .flagsOut(flagsOut), .dataOut(dataOut), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a[7:2])
      6'd1:    return 32'(mMode);
      6'd4:    return 32'(mFlags);
      6'd7:    return 32'(mMask);
      6'd8:    return 32'(statusIn);
      6'd9:    return 32'(mData);
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    case (a[7:2])
      6'd1: mMode = d[7:0];
      6'd2: mFlags = mFlags | d[7:0];
      6'd3: mFlags = mFlags & ~d[7:0];
      6'd5: mMask = mMask | d[7:0];
      6'd6: mMask = mMask & ~d[7:0];
      6'd9: mData = d[15:0];
      default: ;
    endcase
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    lastPulse = cmdPulse;
    modelWrite(a, d);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdCheck(input logic [7:0] a, input string tag);
    logic [31:0] v;
    busRd(a, v);
    chk(v == expRead(a), tag, v, expRead(a));
  endtask

  task automatic settleCheck(input string tag);
    @(negedge clk); @(negedge clk);
    chk(irq == |(statusIn & mMask), tag, 32'(irq), 32'(|(statusIn & mMask)));
    chk(cmdPulse == 4'h0, "R2 pulse one cycle", 32'(cmdPulse), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // reset state
    chk(irq == 1'b0, "R7 irq reset", 32'(irq), 0);
    chk(cmdPulse == 4'h0, "R2 pulse reset", 32'(cmdPulse), 0);
    rstN = 1'b1;
    rdCheck(8'h04, "R3 mode reset");
    rdCheck(8'h10, "R4 flags reset");
    rdCheck(8'h1C, "R5 mask reset");
    rdCheck(8'h24, "R8 data reset");
    // R10: read data stays zero while idle
    @(negedge clk); #1;
    chk(busRdata == 32'h0, "R10 idle rdata", busRdata, 0);

    // R1 + R2: command at misaligned address
    busWr(8'h03, 32'hFFFF_FFF5);
    chk(lastPulse == 4'h5, "R1 R2 cmd pulse", 32'(lastPulse), 5);
    settleCheck("R7 irq after cmd");
    rdCheck(8'h00, "R2 ctrl reads zero");

    // R3 with half-word address, upper bits dropped (R9)
    busWr(8'h06, 32'hABCD_1234);
    rdCheck(8'h04, "R3 R9 mode readback");
    chk(modeOut == 8'h34, "R3 modeOut", 32'(modeOut), 32'h34);

    // R4 set then clear, zeros untouched
    busWr(8'h08, 32'h0000_00A5);
    busWr(8'h09, 32'h0000_0018);
    rdCheck(8'h10, "R4 set accumulates");
    busWr(8'h0C, 32'h0000_0081);
    rdCheck(8'h10, "R4 clear selected");
    chk(flagsOut == mFlags, "R4 flagsOut", 32'(flagsOut), 32'(mFlags));
    rdCheck(8'h08, "R9 set addr reads zero");
    rdCheck(8'h0C, "R9 clr addr reads zero");

    // R5 + R7: mask and interrupt
    statusIn = 8'h10;
    settleCheck("R7 status without mask");
    busWr(8'h14, 32'h0000_0030);
    settleCheck("R7 irq with mask");
    busWr(8'h18, 32'h0000_0010);
    rdCheck(8'h1C, "R5 mask after clear");
    settleCheck("R7 irq masked off");
    rdCheck(8'h20, "R6 status read");

    // R8 data
    busWr(8'h25, 32'h1234_BEEF);
    rdCheck(8'h24, "R8 data readback");
    chk(dataOut == 16'hBEEF, "R8 dataOut", 32'(dataOut), 32'hBEEF);

    // R9 unmapped write then reread everything
    busWr(8'h28, 32'hFFFF_FFFF);
    busWr(8'hFC, 32'hFFFF_FFFF);
    rdCheck(8'h04, "R9 mode intact");
    rdCheck(8'h10, "R9 flags intact");
    rdCheck(8'h1C, "R9 mask intact");
    rdCheck(8'h24, "R9 data intact");
    rdCheck(8'h2C, "R9 unmapped read");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int op;
      a = {6'($urandom_range(0, 12)), 2'($urandom)};
      d = $urandom;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        statusIn = 8'($urandom);
        settleCheck("R7 random irq");
      end else if (op == 1) begin
        busWr(a, d);
        if (a[7:2] == 6'd0)
          chk(lastPulse == d[3:0], "R2 random pulse", 32'(lastPulse), 32'(d[3:0]));
        chk(flagsOut == mFlags, "R4 random flagsOut", 32'(flagsOut), 32'(mFlags));
        chk(modeOut == mMode, "R3 random modeOut", 32'(modeOut), 32'(mMode));
        chk(dataOut == mData, "R8 random dataOut", 32'(dataOut), 32'(mData));
      end else begin
        busRd(a, v);
        chk(v == expRead(a), "R1 R9 random read", v, expRead(a));
      end
    end
    settleCheck("R7 final irq");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule